// File: doc/BRIEF.md
# PLCP Frame Alignment Tracker

This block locks onto the 12-row, 57-octet-per-row physical layer convergence frame in a receive byte stream that is already octet-aligned. Each row starts with two fixed framing octets, then a row identifier octet, one overhead octet and a 53-octet cell. The block searches the stream for a framing pair followed by a legal identifier. It then confirms that candidate on the next row and declares alignment. Once aligned, it checks every row's framing and identifier octets.

It keeps one of three alignment states: aligned, out-of-frame and loss-of-frame. While aligned it emits a strobe per row and a strobe per frame. It reports framing errors as one-cycle pulses and counts them, and it counts every loss of alignment. While loss-of-frame holds, a one-second tick input qualifies a long-duration flag. A framing mode change signalled at run time throws the tracker out of alignment.

Top module: `plcp_framer`

## Requirements
- R1: After reset `oof` is 1; `in_frame`, `lof`, `lof_long`, `frame_err`, both strobes and both counters are 0.
- R2: `in_frame` rises only after the octet sequence 0xF6, 0x28, a valid identifier for row k, 54 further octets, 0xF6, 0x28 and the identifier for row k+1 (mod 12). It becomes 1 in the cycle after that last identifier octet is accepted. The identifiers for rows 0 to 11 are 0x2C, 0x29, 0x25, 0x20, 0x1C, 0x19, 0x15, 0x10, 0x0D, 0x08, 0x04, 0x01.
- R3: While aligned, a row whose first octet is not 0xF6 or whose second octet is not 0x28 gives one `frame_err` pulse in the cycle after the second octet is accepted. `ferr_count` then rises by one a cycle later.
- R4: While aligned, a row with both framing octets wrong moves the block to out-of-frame. A row with only one of them wrong does not.
- R5: While aligned, identifier errors in two consecutive rows move the block to out-of-frame. A single identifier error followed by a correct one does not.
- R6: `oof_count` rises by one only for a transition from aligned to out-of-frame. Out-of-frame is never entered from loss-of-frame except by R10.
- R7: After 8 frames' worth of accepted octets (5472) spent in out-of-frame without reacquiring, the block moves to loss-of-frame.
- R8: From out-of-frame or loss-of-frame, reacquiring framing as in R2 returns the block to aligned and clears `oof` and `lof`.
- R9: `lof_long` sets when loss-of-frame is held at three consecutive rising edges of `sec_tick`. It clears one cycle after loss-of-frame ends.
- R10: A `mode_switch` pulse forces out-of-frame from any state and discards the octet offered in that cycle. It is counted in `oof_count` only when the block was aligned.
- R11: Both counters saturate at all ones. `cnt_clr` clears them in the next cycle and takes priority over an increment.
- R12: While aligned, `row_strb` pulses once per row, in the cycle after that row's first octet is accepted. `frame_strb` pulses with it only for row 0.
- R13: A cycle with `oct_vld` low changes no state, whatever `oct_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oct_vld | input | 1 | An octet is offered on `oct_data` |
| oct_data | input | 8 | Receive octet |
| mode_switch | input | 1 | Framing mode changed; forces out-of-frame |
| sec_tick | input | 1 | One-second tick level, rising edges counted |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| row_strb | output | 1 | Row boundary pulse while aligned |
| frame_strb | output | 1 | Frame boundary pulse while aligned |
| in_frame | output | 1 | Aligned state |
| oof | output | 1 | Out-of-frame state |
| lof | output | 1 | Loss-of-frame state |
| lof_long | output | 1 | Loss-of-frame persisted over three ticks |
| frame_err | output | 1 | Framing octet error pulse |
| ferr_count | output | CNT_W | Saturating framing error count |
| oof_count | output | CNT_W | Saturating out-of-frame event count |

## Verification
On every cycle the assertions check the following. Out-of-frame events and framing-error pulses come only from the aligned state. Loss-of-frame is entered only from out-of-frame. Idle cycles leave the state alone. Frame strobes coincide with row strobes. The counters hold at their maximum and obey the clear. The long-LOF flag never stands without loss-of-frame.

Only the bench's scenarios show that alignment needs two identifiers in sequence and that both error patterns break it while single errors do not. They also show the exact 5472-octet loss-of-frame threshold, the three-tick qualification, and the strobe counts over two full frames.

// File: rtl/plcp_pkg.sv
package plcp_pkg;

    localparam int ROW_LEN  = 57;
    localparam int ROWS     = 12;
    localparam int POS_W    = $clog2(ROW_LEN);
    localparam int ROW_W    = $clog2(ROWS);
    localparam logic [7:0] FRAME_B0 = 8'hF6;
    localparam logic [7:0] FRAME_B1 = 8'h28;

    typedef enum logic [1:0] {
        ST_IF  = 2'd0,
        ST_OOF = 2'd1,
        ST_LOF = 2'd2
    } align_e;

    typedef enum logic [1:0] {
        H_SEEK    = 2'd0,
        H_ID      = 2'd1,
        H_CONFIRM = 2'd2
    } hunt_e;

    function automatic logic [7:0] row_id(input logic [ROW_W-1:0] r);
        case (r)
            4'd0:    row_id = 8'h2C;
            4'd1:    row_id = 8'h29;
            4'd2:    row_id = 8'h25;
            4'd3:    row_id = 8'h20;
            4'd4:    row_id = 8'h1C;
            4'd5:    row_id = 8'h19;
            4'd6:    row_id = 8'h15;
            4'd7:    row_id = 8'h10;
            4'd8:    row_id = 8'h0D;
            4'd9:    row_id = 8'h08;
            4'd10:   row_id = 8'h04;
            4'd11:   row_id = 8'h01;
            default: row_id = 8'h00;
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] row_after(input logic [ROW_W-1:0] r);
        row_after = (r == ROW_W'(ROWS - 1)) ? '0 : r + 1'b1;
    endfunction

endpackage

// File: rtl/plcp_octet_check.sv
module plcp_octet_check
    import plcp_pkg::*;
(
    input  logic [7:0]       octet,
    input  logic [ROW_W-1:0] row_sel,
    output logic             is_b0,
    output logic             is_b1,
    output logic             id_hit,
    output logic             id_any,
    output logic [ROW_W-1:0] id_idx
);

    assign is_b0  = (octet == FRAME_B0);
    assign is_b1  = (octet == FRAME_B1);
    assign id_hit = (octet == row_id(row_sel));

    always_comb begin
        id_any = 1'b0;
        id_idx = '0;
        for (int k = 0; k < ROWS; k++) begin
            if (octet == row_id(ROW_W'(k))) begin
                id_any = 1'b1;
                id_idx = ROW_W'(k);
            end
        end
    end

endmodule

// File: rtl/plcp_align_fsm.sv
module plcp_align_fsm
    import plcp_pkg::*;
#(
    parameter int LOF_FRAMES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oct_vld,
    input  logic [7:0] oct_data,
    input  logic       mode_switch,
    output align_e     state,
    output logic       row_p,
    output logic       frame_p,
    output logic       ferr_p,
    output logic       oof_p
);

    localparam int LOF_OCT = ROW_LEN * ROWS * LOF_FRAMES;
    localparam int TMR_W   = $clog2(LOF_OCT);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ROW_LEN - 1);

    typedef struct packed {
        align_e             st;
        hunt_e              hm;
        logic [POS_W-1:0]   pos;
        logic [ROW_W-1:0]   row;
        logic               b0_bad;
        logic               id_bad;
        logic               prev_b0;
        logic [TMR_W-1:0]   tmr;
        logic               row_p;
        logic               frame_p;
        logic               ferr_p;
        logic               oof_p;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st: ST_OOF, hm: H_SEEK, pos: '0, row: '0, b0_bad: 1'b0, id_bad: 1'b0,
        prev_b0: 1'b0, tmr: '0, row_p: 1'b0, frame_p: 1'b0, ferr_p: 1'b0, oof_p: 1'b0
    };

    fsm_t q, d;

    logic             is_b0, is_b1, id_hit, id_any;
    logic [ROW_W-1:0] id_idx, row_sel;
    logic             go_oof, restart, acquired;

    assign row_sel = (q.st == ST_IF) ? q.row : row_after(q.row);

    plcp_octet_check u_chk (
        .octet   (oct_data),
        .row_sel (row_sel),
        .is_b0   (is_b0),
        .is_b1   (is_b1),
        .id_hit  (id_hit),
        .id_any  (id_any),
        .id_idx  (id_idx)
    );

    always_comb begin
        d         = q;
        d.row_p   = 1'b0;
        d.frame_p = 1'b0;
        d.ferr_p  = 1'b0;
        d.oof_p   = 1'b0;
        go_oof    = 1'b0;
        restart   = 1'b0;
        acquired  = 1'b0;
        if (mode_switch) begin
            go_oof  = 1'b1;
            d.oof_p = (q.st == ST_IF);
        end else if (oct_vld) begin
            if (q.st == ST_IF) begin
                if (q.pos == POS_W'(0)) begin
                    d.b0_bad  = !is_b0;
                    d.row_p   = 1'b1;
                    d.frame_p = (q.row == '0);
                end else if (q.pos == POS_W'(1)) begin
                    d.ferr_p = q.b0_bad || !is_b1;
                    if (q.b0_bad && !is_b1) begin
                        go_oof  = 1'b1;
                        d.oof_p = 1'b1;
                    end
                end else if (q.pos == POS_W'(2)) begin
                    if (id_hit) begin
                        d.id_bad = 1'b0;
                    end else if (q.id_bad) begin
                        go_oof  = 1'b1;
                        d.oof_p = 1'b1;
                    end else begin
                        d.id_bad = 1'b1;
                    end
                end
                if (q.pos == LAST_POS) begin
                    d.pos = '0;
                    d.row = row_after(q.row);
                end else begin
                    d.pos = q.pos + 1'b1;
                end
            end else begin
                unique case (q.hm)
                    H_SEEK: begin
                        d.prev_b0 = is_b0;
                        if (q.prev_b0 && is_b1) d.hm = H_ID;
                    end
                    H_ID: begin
                        if (id_any) begin
                            d.row = id_idx;
                            d.pos = POS_W'(3);
                            d.hm  = H_CONFIRM;
                        end else begin
                            restart = 1'b1;
                        end
                    end
                    default: begin
                        if (q.pos == POS_W'(0)) begin
                            restart = !is_b0;
                        end else if (q.pos == POS_W'(1)) begin
                            restart = !is_b1;
                        end else if (q.pos == POS_W'(2)) begin
                            acquired = id_hit;
                            restart  = !id_hit;
                        end
                        if (q.pos == LAST_POS) d.pos = '0;
                        else                   d.pos = q.pos + 1'b1;
                    end
                endcase
                if (restart) begin
                    d.hm      = H_SEEK;
                    d.prev_b0 = is_b0;
                end
                if (acquired) begin
                    d.st      = ST_IF;
                    d.row     = row_after(q.row);
                    d.pos     = POS_W'(3);
                    d.b0_bad  = 1'b0;
                    d.id_bad  = 1'b0;
                    d.hm      = H_SEEK;
                    d.prev_b0 = 1'b0;
                end else if (q.st == ST_OOF) begin
                    if (q.tmr == TMR_W'(LOF_OCT - 1)) d.st  = ST_LOF;
                    else                              d.tmr = q.tmr + 1'b1;
                end
            end
        end
        if (go_oof) begin
            d.st      = ST_OOF;
            d.hm      = H_SEEK;
            d.prev_b0 = 1'b0;
            d.tmr     = '0;
            d.b0_bad  = 1'b0;
            d.id_bad  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= d;
    end

    assign state   = q.st;
    assign row_p   = q.row_p;
    assign frame_p = q.frame_p;
    assign ferr_p  = q.ferr_p;
    assign oof_p   = q.oof_p;

    // R6: an out-of-frame event is flagged only when leaving the aligned state
    a_r6_oof_from_if: assert property (@(posedge clk) disable iff (!rst_n)
        q.oof_p |-> ($past(q.st) == ST_IF && q.st == ST_OOF));

    // R7: loss-of-frame is reached only from out-of-frame
    a_r7_lof_from_oof: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOF && $past(q.st) != ST_LOF) |-> ($past(q.st) == ST_OOF));

    // R3: framing error pulses come only from the aligned state
    a_r3_ferr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        q.ferr_p |-> ($past(q.st) == ST_IF));

    // R2: alignment is gained only at the end of a confirmation row
    a_r2_acq_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IF && $past(q.st) != ST_IF) |-> ($past(q.hm) == H_CONFIRM && $past(oct_vld)));

    // R12: a frame strobe always coincides with a row strobe
    a_r12_frame_on_row: assert property (@(posedge clk) disable iff (!rst_n)
        q.frame_p |-> q.row_p);

    // R13: idle cycles leave the alignment state unchanged
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!oct_vld && !mode_switch) |=> ($stable(q.st) && $stable(q.pos) && !q.row_p));

endmodule

// File: rtl/plcp_lof_persist.sv
module plcp_lof_persist #(
    parameter int TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lof,
    input  logic tick,
    output logic long_flag
);

    localparam int TW = $clog2(TICKS + 1);

    typedef struct packed {
        logic          tick_prev;
        logic [TW-1:0] cnt;
        logic          long_f;
    } per_t;

    per_t q, d;
    logic rise;

    assign rise = tick && !q.tick_prev;

    always_comb begin
        d           = q;
        d.tick_prev = tick;
        if (!lof) begin
            d.cnt = '0;
        end else if (rise && q.cnt != TW'(TICKS)) begin
            d.cnt = q.cnt + 1'b1;
        end
        d.long_f = lof && (d.cnt == TW'(TICKS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign long_flag = q.long_f;

    // R9: the long flag never stands without loss-of-frame in the cycle before
    a_r9_long_needs_lof: assert property (@(posedge clk) disable iff (!rst_n)
        q.long_f |-> $past(lof));

    // R9: the long flag can only rise on a tick rising edge
    a_r9_long_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.long_f) |-> $past(tick));

endmodule

// File: rtl/plcp_sat_cnt.sv
module plcp_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                   cnt_d = '0;
        else if (inc && ~&cnt_q)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R11: clear takes effect in the next cycle
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R11: the count holds at all ones
    a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_q && !clr) |=> (&cnt_q));

    // R11: without an event the count does not move
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt_q));

endmodule

// File: rtl/plcp_framer.sv
module plcp_framer
    import plcp_pkg::*;
#(
    parameter int LOF_FRAMES = 8,
    parameter int LONG_TICKS = 3,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oct_vld,
    input  logic [7:0]       oct_data,
    input  logic             mode_switch,
    input  logic             sec_tick,
    input  logic             cnt_clr,
    output logic             row_strb,
    output logic             frame_strb,
    output logic             in_frame,
    output logic             oof,
    output logic             lof,
    output logic             lof_long,
    output logic             frame_err,
    output logic [CNT_W-1:0] ferr_count,
    output logic [CNT_W-1:0] oof_count
);

    localparam int N_CNT = 2;

    align_e           st;
    logic             ferr_p, oof_p;
    logic [N_CNT-1:0] inc_v;
    logic [CNT_W-1:0] cnt_v [N_CNT];

    plcp_align_fsm #(.LOF_FRAMES(LOF_FRAMES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .oct_vld     (oct_vld),
        .oct_data    (oct_data),
        .mode_switch (mode_switch),
        .state       (st),
        .row_p       (row_strb),
        .frame_p     (frame_strb),
        .ferr_p      (ferr_p),
        .oof_p       (oof_p)
    );

    assign in_frame  = (st == ST_IF);
    assign oof       = (st == ST_OOF);
    assign lof       = (st == ST_LOF);
    assign frame_err = ferr_p;

    plcp_lof_persist #(.TICKS(LONG_TICKS)) u_persist (
        .clk       (clk),
        .rst_n     (rst_n),
        .lof       (lof),
        .tick      (sec_tick),
        .long_flag (lof_long)
    );

    assign inc_v = {oof_p, ferr_p};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        plcp_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (inc_v[g]),
            .cnt   (cnt_v[g])
        );
    end

    assign ferr_count = cnt_v[0];
    assign oof_count  = cnt_v[1];

endmodule

// File: tb/plcp_framer_test.sv
module plcp_framer_test;

    localparam int CW       = 4;
    localparam int MAXC     = (1 << CW) - 1;
    localparam int LOF_OCTS = 57 * 12 * 8;
    localparam logic [7:0] B0 = 8'hF6;
    localparam logic [7:0] B1 = 8'h28;

    logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0, ms = 1'b0, tick = 1'b0, clr = 1'b0;
    logic [7:0] dat = 8'h00;
    logic row_strb, frame_strb, in_frame, oof, lof, lof_long, frame_err;
    logic [CW-1:0] ferr_count, oof_count;

    plcp_framer #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .oct_vld(vld), .oct_data(dat), .mode_switch(ms),
        .sec_tick(tick), .cnt_clr(clr), .row_strb(row_strb), .frame_strb(frame_strb),
        .in_frame(in_frame), .oof(oof), .lof(lof), .lof_long(lof_long),
        .frame_err(frame_err), .ferr_count(ferr_count), .oof_count(oof_count)
    );

    always #10 clk = ~clk;

    int vecs = 0, miss = 0;
    int rows_seen = 0, frames_seen = 0, ferr_seen = 0;
    int exp_ferr = 0, exp_oof = 0, cur_row = 0, snap = 0;
    bit gaps = 1'b0, done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            rows_seen   += int'(row_strb);
            frames_seen += int'(frame_strb);
            ferr_seen   += int'(frame_err);
        end
    end

    function automatic logic [7:0] id_of(input int r);
        case (r)
            0: id_of = 8'h2C;  1: id_of = 8'h29;  2: id_of = 8'h25;  3: id_of = 8'h20;
            4: id_of = 8'h1C;  5: id_of = 8'h19;  6: id_of = 8'h15;  7: id_of = 8'h10;
            8: id_of = 8'h0D;  9: id_of = 8'h08; 10: id_of = 8'h04; default: id_of = 8'h01;
        endcase
    endfunction

    function automatic int nxt(input int r);
        return (r == 11) ? 0 : r + 1;
    endfunction

    function automatic int sat(input int v);
        return (v >= MAXC) ? MAXC : v + 1;
    endfunction

    function automatic logic [7:0] rnd_oct();
        logic [7:0] b = 8'($urandom);
        return (b == B0) ? 8'h00 : b;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        vecs++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        if (gaps && $urandom_range(0, 4) == 0) begin
            @(negedge clk); vld = 1'b0; dat = 8'($urandom);
        end
        @(negedge clk); vld = 1'b1; dat = b;
    endtask

    task automatic settle();
        @(negedge clk); vld = 1'b0;
    endtask

    task automatic send_row(input int r, input logic [7:0] a, input logic [7:0] b, input logic [7:0] id, input int n);
        for (int p = 0; p < n; p++) begin
            if (p == 0)      put(a);
            else if (p == 1) put(b);
            else if (p == 2) put(id);
            else             put(rnd_oct());
        end
    endtask

    task automatic send_tail(input int n);
        for (int p = 0; p < n; p++) put(rnd_oct());
    endtask

    task automatic good_rows(input int n);
        for (int i = 0; i < n; i++) begin
            send_row(cur_row, B0, B1, id_of(cur_row), 57);
            cur_row = nxt(cur_row);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic pulse_ms();
        @(negedge clk); ms = 1'b1;
        @(negedge clk); ms = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", int'(oof), 1, "oof after reset");
        check("R1", int'(in_frame), 0, "in_frame after reset");
        check("R1", int'(lof), 0, "lof after reset");
        check("R1", int'(lof_long), 0, "lof_long after reset");
        check("R1", int'(ferr_count), 0, "ferr_count after reset");
        check("R1", int'(oof_count), 0, "oof_count after reset");
        check("R1", int'(row_strb), 0, "row_strb after reset");

        // R2 acquisition needs two identifiers in sequence
        gaps = 1'b1;
        repeat ($urandom_range(5, 120)) put(rnd_oct());
        cur_row = $urandom_range(0, 11);
        send_row(cur_row, B0, B1, id_of(cur_row), 57);
        cur_row = nxt(cur_row);
        settle();
        check("R2", int'(in_frame), 0, "in_frame after first row");
        send_row(cur_row, B0, B1, id_of(cur_row), 2);
        settle();
        check("R2", int'(in_frame), 0, "in_frame before second identifier");
        put(id_of(cur_row));
        settle();
        check("R2", int'(in_frame), 1, "in_frame after second identifier");
        check("R8", int'(oof), 0, "oof cleared on acquisition");
        send_tail(54);
        cur_row = nxt(cur_row);

        // R12 strobes over 24 rows
        settle();
        rows_seen = 0; frames_seen = 0;
        good_rows(24);
        settle();
        check("R12", rows_seen, 24, "row strobes over 24 rows");
        check("R12", frames_seen, 2, "frame strobes over 24 rows");

        // R3 single framing octet errors, R4 negative case
        ferr_seen = 0;
        send_row(cur_row, 8'h00, B1, id_of(cur_row), 57); cur_row = nxt(cur_row);
        exp_ferr = sat(exp_ferr);
        settle();
        check("R3", ferr_seen, 1, "frame_err pulses after first-octet error");
        check("R4", int'(in_frame), 1, "in_frame after single framing error");
        send_row(cur_row, B0, 8'h3C, id_of(cur_row), 57); cur_row = nxt(cur_row);
        exp_ferr = sat(exp_ferr);
        settle(); @(negedge clk);
        check("R3", ferr_seen, 2, "frame_err pulses after second-octet error");
        check("R3", int'(ferr_count), exp_ferr, "ferr_count");
        check("R4", int'(in_frame), 1, "in_frame after second-octet error");

        // R5 isolated identifier error, then two in a row
        send_row(cur_row, B0, B1, 8'hFF, 57); cur_row = nxt(cur_row);
        good_rows(1);
        send_row(cur_row, B0, B1, 8'hAA, 57); cur_row = nxt(cur_row);
        settle();
        check("R5", int'(in_frame), 1, "in_frame after isolated identifier errors");
        send_row(cur_row, B0, B1, 8'h55, 3);
        settle();
        check("R5", int'(oof), 1, "oof after two consecutive identifier errors");
        exp_oof = sat(exp_oof);
        @(negedge clk);
        check("R6", int'(oof_count), exp_oof, "oof_count after identifier loss");
        send_tail(54); cur_row = nxt(cur_row);

        // R8 reacquire from out-of-frame
        good_rows(2);
        settle();
        check("R8", int'(in_frame), 1, "reacquired from oof");

        // R4 both framing octets wrong
        ferr_seen = 0;
        send_row(cur_row, 8'h11, 8'h22, id_of(cur_row), 2);
        settle();
        check("R4", int'(oof), 1, "oof after double framing error");
        exp_ferr = sat(exp_ferr); exp_oof = sat(exp_oof);
        @(negedge clk);
        check("R3", ferr_seen, 1, "frame_err on double error");
        check("R6", int'(oof_count), exp_oof, "oof_count after double error");
        send_tail(55); cur_row = nxt(cur_row);

        // R7 loss-of-frame threshold, with R13 idle gaps mixed in
        send_tail(LOF_OCTS - 55 - 1);
        settle();
        check("R7", int'(lof), 0, "lof one octet before threshold");
        check("R7", int'(oof), 1, "oof one octet before threshold");
        put(rnd_oct());
        settle();
        check("R7", int'(lof), 1, "lof at threshold");
        check("R6", int'(oof_count), exp_oof, "oof_count unchanged by lof");

        // R9 long loss-of-frame qualification
        pulse_tick(); pulse_tick();
        check("R9", int'(lof_long), 0, "lof_long after two ticks");
        pulse_tick();
        check("R9", int'(lof_long), 1, "lof_long after three ticks");

        // R8 recovery from loss-of-frame, R9 clear
        good_rows(2);
        settle();
        check("R8", int'(in_frame), 1, "reacquired from lof");
        check("R8", int'(lof), 0, "lof cleared on reacquire");
        @(negedge clk);
        check("R9", int'(lof_long), 0, "lof_long cleared after lof ends");

        // R13 idle cycles carrying framing patterns
        snap = rows_seen;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); vld = 1'b0; dat = (i % 2 == 0) ? B0 : B1;
        end
        check("R13", rows_seen, snap, "row strobes during idle");
        check("R13", int'(in_frame), 1, "in_frame during idle");
        good_rows(1);
        settle();
        check("R13", int'(in_frame), 1, "alignment kept across idle gap");

        // R10 mode switch
        pulse_ms();
        check("R10", int'(oof), 1, "oof after mode switch");
        exp_oof = sat(exp_oof);
        @(negedge clk);
        check("R10", int'(oof_count), exp_oof, "oof_count after mode switch in frame");
        pulse_ms();
        @(negedge clk);
        check("R10", int'(oof_count), exp_oof, "oof_count after mode switch while oof");
        good_rows(2);
        settle();
        check("R10", int'(in_frame), 1, "reacquired after mode switch");

        // R11 clear, then random rows driving the counter to saturation
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R11", int'(ferr_count), 0, "ferr_count after clear");
        check("R11", int'(oof_count), 0, "oof_count after clear");
        exp_ferr = 0; exp_oof = 0; ferr_seen = 0;
        for (int i = 0; i < 30; i++) begin
            int kind = $urandom_range(0, 2);
            if (kind == 0) begin
                send_row(cur_row, B0, B1, id_of(cur_row), 57);
            end else if (kind == 1) begin
                send_row(cur_row, 8'h6F, B1, id_of(cur_row), 57);
                exp_ferr = sat(exp_ferr);
            end else begin
                send_row(cur_row, B0, 8'h82, id_of(cur_row), 57);
                exp_ferr = sat(exp_ferr);
            end
            cur_row = nxt(cur_row);
        end
        send_row(cur_row, 8'h00, B1, id_of(cur_row), 57);
        repeat (MAXC) exp_ferr = sat(exp_ferr);
        cur_row = nxt(cur_row);
        for (int i = 0; i < MAXC; i++) begin
            send_row(cur_row, 8'h00, B1, id_of(cur_row), 57);
            cur_row = nxt(cur_row);
        end
        settle(); @(negedge clk);
        check("R11", int'(ferr_count), exp_ferr, "ferr_count saturated");
        check("R4", int'(in_frame), 1, "in_frame through single framing errors");

        // R11 clear wins over a simultaneous increment
        send_row(cur_row, 8'h00, B1, id_of(cur_row), 2);
        @(negedge clk); vld = 1'b0; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R11", int'(ferr_count), 0, "clear with coincident framing error");
        send_tail(55);
        settle();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule